// File: doc/BRIEF.md
# Bit-Sliced Capture Sample Reassembler

This block takes one group of eight 32-bit words from a capture front end and rebuilds sixteen consecutive 12-bit samples from it. In that front end, four single-bit shifters each hold one sample bit per position. Two pairs of 4-bit parallel shifters each hold one nibble per position. The reassembler undoes that slicing. It emits the samples one at a time on a valid/ready stream, in index order from 0 to 15.

The block accepts a new word group only once all sixteen samples of the current group have left on the output stream. While the samples go out, a built-in checker compares each sample with the previous one. A sample must equal the previous sample plus one, modulo 4096. The previous sample is kept across group boundaries. The checker reports two things:
- A sticky error flag, which stays set until a synchronous clear.
- A per-group "data correct" indication, which is set again each time a group is accepted.

The test source is a free-running binary counter. The checker shows whether the capture path dropped, duplicated or corrupted any data.

Top module: `slice_sample_reasm`

## Requirements
- R1: After reset, `smp_valid_o` is 0, `grp_ready_o` is 1, `seq_err_o` is 0 and `grp_ok_o` is 1.
- R2: Sample bits 3:0 of sample i come from the nibble of word 2 (i < 8) or word 3 (i >= 8) at bit offset 4*(i mod 8). Word w sits at `grp_words_i[32*w+31 : 32*w]`.
- R3: Sample bits 7:4 of sample i come from word 6 (i < 8) or word 7 (i >= 8), using the same nibble offset rule as R2.
- R4: Sample bits 8, 9, 10 and 11 of sample i are bit 16+i of words 0, 1, 4 and 5 respectively. Bits 15:0 of those words have no effect on any output.
- R5: Each accepted group yields exactly 16 samples, leaving in index order 0, 1, …, 15. After sample 15 is consumed, `smp_valid_o` is 0 in the next cycle.
- R6: `grp_ready_o` is 1 exactly when no group is held. A group is taken on a clock edge where `grp_valid_i` and `grp_ready_o` are both 1. Sample 0 is then offered with `smp_valid_o` = 1 in the following cycle.
- R7: While `smp_valid_o` is 1 and `smp_ready_i` is 0, `smp_valid_o` stays 1 and `smp_data_o` stays stable in the next cycle.
- R8: A consumed sample that differs from (previous consumed sample + 1) mod 4096 sets `seq_err_o` in the cycle after the handshake. The flag stays set until `clear_i`.
- R9: The previous-sample value carries across group boundaries, so a discontinuity between the last sample of one group and the first sample of the next is flagged. The first sample consumed after reset or clear is not checked.
- R10: When `clear_i` is 1 at a clock edge, `seq_err_o` becomes 0 and `grp_ok_o` becomes 1, and the next consumed sample is treated as first.
- R11: `grp_ok_o` becomes 1 in the cycle after a group is accepted. It becomes 0 in the cycle after a sequence mismatch and stays 0 until the next acceptance or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the sequence checker |
| grp_valid_i | input | 1 | Word group offered |
| grp_ready_o | output | 1 | Block can take a word group |
| grp_words_i | input | 256 | Eight 32-bit captured words, word w at bits 32*w+31:32*w |
| smp_valid_o | output | 1 | Sample available |
| smp_ready_i | input | 1 | Downstream takes the sample |
| smp_data_o | output | 12 | Reassembled sample |
| seq_err_o | output | 1 | Sticky sequence error |
| grp_ok_o | output | 1 | No mismatch in the current group |

## Verification
Most faults in this block show up at the ports within a few cycles:
- A wrong lane mapping or nibble offset corrupts `smp_data_o` on the first sample that uses the faulty lane. For a lane that picks the wrong word half, that is sample 0 or sample 8.
- A sample index that skips or stalls puts the wrong sample on the stream at once. It also breaks the expected counter sequence, so `seq_err_o` rises one cycle after the handshake.
- A previous-sample register that is lost at a group boundary hides a boundary gap. The groups sent after a clear expose this.
- Backpressure patterns expose data that changes while the downstream stalls.
- Single-bit corruptions in every lane group, including the wrap from 4095 to 0, expose a checker that misses mismatches or flags good data.

// File: rtl/slice_reasm_pkg.sv
package slice_reasm_pkg;
  localparam int WORD_W        = 32;
  localparam int NUM_WORDS     = 8;
  localparam int SAMPLE_W      = 12;
  localparam int GROUP_LEN     = 16;
  localparam int NIB_W         = 4;
  localparam int HALF_LEN      = GROUP_LEN / 2;
  localparam int IDX_W         = $clog2(GROUP_LEN);
  localparam int NUM_BIT_LANES = SAMPLE_W - 2 * NIB_W;
  localparam int BIT_LANE_BASE = 16;

  // word pairs feeding the nibble lanes (first half / second half of group)
  localparam int LO_NIB_WORD_A = 2;
  localparam int LO_NIB_WORD_B = 3;
  localparam int HI_NIB_WORD_A = 6;
  localparam int HI_NIB_WORD_B = 7;

  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [IDX_W-1:0]    idx_t;

  // single-bit lane k drives sample bit 2*NIB_W+k
  function automatic int bit_lane_word(input int k);
    case (k)
      0:       return 0;
      1:       return 1;
      2:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/group_buf.sv
module group_buf
  import slice_reasm_pkg::*;
#(
  parameter int N_WORDS = NUM_WORDS,
  parameter int W_W     = WORD_W,
  parameter int G_LEN   = GROUP_LEN,
  localparam int I_W    = $clog2(G_LEN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   grp_valid_i,
  input  logic [N_WORDS*W_W-1:0] grp_words_i,
  input  logic                   adv_i,
  output logic                   grp_ready_o,
  output logic                   accept_o,
  output logic                   held_o,
  output logic [N_WORDS*W_W-1:0] words_o,
  output logic [I_W-1:0]         idx_o
);
  localparam logic [I_W-1:0] LAST_IDX = I_W'(G_LEN - 1);

  logic                   held_q;
  logic [N_WORDS*W_W-1:0] words_q;
  logic [I_W-1:0]         idx_q;

  assign grp_ready_o = ~held_q;
  assign accept_o    = grp_valid_i & ~held_q;
  assign held_o      = held_q;
  assign words_o     = words_q;
  assign idx_o       = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      held_q <= 1'b1;
      idx_q  <= '0;
    end else if (adv_i && held_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) held_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept_o) words_q <= grp_words_i;
  end

  AST_ACCEPT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> held_o && idx_o == '0); // R6
  AST_LAST_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && held_o && idx_o == LAST_IDX) |=> !held_o); // R5
  AST_IDX_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && held_o && idx_o != LAST_IDX) |=> held_o && idx_o == $past(idx_o) + 1'b1); // R5
endmodule

// File: rtl/nibble_pick.sv
module nibble_pick
  import slice_reasm_pkg::*;
#(
  parameter int W_W   = WORD_W,
  parameter int N_W   = NIB_W,
  parameter int G_LEN = GROUP_LEN,
  localparam int I_W  = $clog2(G_LEN),
  localparam int SH_W = $clog2(N_W)
) (
  input  logic [W_W-1:0] word_first_i,
  input  logic [W_W-1:0] word_second_i,
  input  logic [I_W-1:0] idx_i,
  output logic [N_W-1:0] nib_o
);
  logic [W_W-1:0]        word_sel;
  logic [I_W-2+SH_W:0]   bit_off;

  // upper index bit picks the word, the rest picks the nibble within it
  assign word_sel = idx_i[I_W-1] ? word_second_i : word_first_i;
  assign bit_off  = {idx_i[I_W-2:0], {SH_W{1'b0}}};
  assign nib_o    = word_sel[bit_off +: N_W];
endmodule

// File: rtl/sample_unpack.sv
module sample_unpack
  import slice_reasm_pkg::*;
#(
  parameter int N_WORDS = NUM_WORDS,
  parameter int W_W     = WORD_W,
  parameter int S_W     = SAMPLE_W,
  parameter int N_W     = NIB_W,
  parameter int G_LEN   = GROUP_LEN,
  localparam int I_W    = $clog2(G_LEN),
  localparam int N_BITS = S_W - 2 * N_W
) (
  input  logic [N_WORDS*W_W-1:0] words_i,
  input  logic [I_W-1:0]         idx_i,
  output logic [S_W-1:0]         sample_o
);
  logic [W_W-1:0] w [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_split
    assign w[g] = words_i[g*W_W +: W_W];
  end

  nibble_pick #(.W_W(W_W), .N_W(N_W), .G_LEN(G_LEN)) i_lo_nib (
    .word_first_i  (w[LO_NIB_WORD_A]),
    .word_second_i (w[LO_NIB_WORD_B]),
    .idx_i         (idx_i),
    .nib_o         (sample_o[N_W-1:0])
  );

  nibble_pick #(.W_W(W_W), .N_W(N_W), .G_LEN(G_LEN)) i_hi_nib (
    .word_first_i  (w[HI_NIB_WORD_A]),
    .word_second_i (w[HI_NIB_WORD_B]),
    .idx_i         (idx_i),
    .nib_o         (sample_o[2*N_W-1:N_W])
  );

  for (genvar k = 0; k < N_BITS; k++) begin : g_bit_lane
    localparam int SRC = bit_lane_word(k);
    logic [G_LEN-1:0] lane_bits;
    assign lane_bits            = w[SRC][BIT_LANE_BASE +: G_LEN];
    assign sample_o[2*N_W + k]  = lane_bits[idx_i];
  end
endmodule

// File: rtl/seq_check.sv
module seq_check
  import slice_reasm_pkg::*;
#(
  parameter int S_W = SAMPLE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           accept_i,
  input  logic           fire_i,
  input  logic [S_W-1:0] data_i,
  output logic           err_o,
  output logic           grp_ok_o
);
  logic [S_W-1:0] prev_q;
  logic           prev_vld_q;
  logic           err_q;
  logic           ok_q;
  logic           mismatch;

  assign mismatch = fire_i & prev_vld_q & (data_i != S_W'(prev_q + 1'b1));
  assign err_o    = err_q;
  assign grp_ok_o = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      err_q      <= 1'b0;
      ok_q       <= 1'b1;
    end else if (clear_i) begin
      prev_vld_q <= 1'b0;
      err_q      <= 1'b0;
      ok_q       <= 1'b1;
    end else begin
      if (fire_i) begin
        prev_q     <= data_i;
        prev_vld_q <= 1'b1;
      end
      if (mismatch) err_q <= 1'b1;
      if (accept_i)      ok_q <= 1'b1;
      else if (mismatch) ok_q <= 1'b0;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clear_i) |=> err_o); // R8
  AST_CLEAR_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!err_o && grp_ok_o)); // R10
  AST_OK_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> grp_ok_o); // R11
  AST_OK_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grp_ok_o && !accept_i && !clear_i) |=> !grp_ok_o); // R11
endmodule

// File: rtl/slice_sample_reasm.sv
module slice_sample_reasm
  import slice_reasm_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic                          grp_valid_i,
  output logic                          grp_ready_o,
  input  logic [NUM_WORDS*WORD_W-1:0]   grp_words_i,
  output logic                          smp_valid_o,
  input  logic                          smp_ready_i,
  output logic [SAMPLE_W-1:0]           smp_data_o,
  output logic                          seq_err_o,
  output logic                          grp_ok_o
);
  logic                        accept;
  logic                        held;
  logic                        fire;
  logic [NUM_WORDS*WORD_W-1:0] words_q;
  idx_t                        idx;
  sample_t                     sample;

  assign fire        = held & smp_ready_i;
  assign smp_valid_o = held;
  assign smp_data_o  = sample;

  group_buf #(.N_WORDS(NUM_WORDS), .W_W(WORD_W), .G_LEN(GROUP_LEN)) i_group_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grp_valid_i (grp_valid_i),
    .grp_words_i (grp_words_i),
    .adv_i       (fire),
    .grp_ready_o (grp_ready_o),
    .accept_o    (accept),
    .held_o      (held),
    .words_o     (words_q),
    .idx_o       (idx)
  );

  sample_unpack #(
    .N_WORDS(NUM_WORDS), .W_W(WORD_W), .S_W(SAMPLE_W), .N_W(NIB_W), .G_LEN(GROUP_LEN)
  ) i_sample_unpack (
    .words_i  (words_q),
    .idx_i    (idx),
    .sample_o (sample)
  );

  seq_check #(.S_W(SAMPLE_W)) i_seq_check (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .accept_i (accept),
    .fire_i   (fire),
    .data_i   (sample),
    .err_o    (seq_err_o),
    .grp_ok_o (grp_ok_o)
  );

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_data_o))); // R7
  AST_NO_ACCEPT_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> !grp_ready_o); // R6
endmodule

// File: tb/test_slice_sample_reasm.sv
module test_slice_sample_reasm;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic         grp_valid_i = 1'b0;
  logic         grp_ready_o;
  logic [255:0] grp_words_i = '0;
  logic         smp_valid_o;
  logic         smp_ready_i = 1'b0;
  logic [11:0]  smp_data_o;
  logic         seq_err_o;
  logic         grp_ok_o;

  int tests = 0;
  int fails = 0;
  int rdy_mode = 0;
  int cyc = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  logic [11:0] m_prev = '0;
  bit          m_pv = 0;
  bit          m_err = 0;
  bit          m_ok = 1;
  bit          stall_prev = 0;
  logic [11:0] stall_data = '0;
  bit          acc_prev = 0;
  int          in_grp = 0;

  always #2 clk_i = ~clk_i;

  slice_sample_reasm i_slice_sample_reasm (.*);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // driver: builds words from samples, pushes expected items, offers group
  task automatic send_group(input int base, input int bad_idx, input int bad_bit);
    logic [31:0] w [8];
    logic [11:0] s;
    for (int k = 0; k < 8; k++) w[k] = 32'h0;
    // junk in the unused lower halves of the single-bit lane words (R4)
    w[0][15:0] = 16'hA5C3; w[1][15:0] = 16'h5A3C;
    w[4][15:0] = 16'hFFFF; w[5][15:0] = 16'h1234;
    for (int i = 0; i < 16; i++) begin
      s = 12'(base + i);
      if (i == bad_idx) s[bad_bit] = ~s[bad_bit];
      exp_q.push_back(s);
      if (i < 8) begin
        w[2][(i%8)*4 +: 4] = s[3:0];
        w[6][(i%8)*4 +: 4] = s[7:4];
      end else begin
        w[3][(i%8)*4 +: 4] = s[3:0];
        w[7][(i%8)*4 +: 4] = s[7:4];
      end
      w[0][16+i] = s[8];
      w[1][16+i] = s[9];
      w[4][16+i] = s[10];
      w[5][16+i] = s[11];
    end
    @(posedge clk_i); #1;
    for (int k = 0; k < 8; k++) grp_words_i[k*32 +: 32] = w[k];
    grp_valid_i = 1'b1;
    forever begin
      @(negedge clk_i);
      if (grp_ready_o) break;
    end
    @(posedge clk_i); #1;
    grp_valid_i = 1'b0;
    grp_words_i = '1;
  endtask

  task automatic drain();
    forever begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && !smp_valid_o) break;
    end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic do_clear();
    @(posedge clk_i); #1;
    clear_i = 1'b1;
    @(posedge clk_i); #1;
    clear_i = 1'b0;
  endtask

  // ready pattern driver
  initial begin
    forever begin
      @(posedge clk_i); #1;
      cyc++;
      case (rdy_mode)
        0: smp_ready_i = 1'b1;
        1: smp_ready_i = cyc[0];
        2: smp_ready_i = (cyc % 3) != 0;
        default: smp_ready_i = (cyc % 7) > 4;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    logic [11:0] e;
    forever begin
      @(negedge clk_i);
      if (rst_ni && !done) begin
        check(seq_err_o == m_err, "R8 R9 R10 seq_err_o", seq_err_o, m_err);
        check(grp_ok_o == m_ok, "R11 grp_ok_o", grp_ok_o, m_ok);
        if (smp_valid_o) check(!grp_ready_o, "R6 ready while held", grp_ready_o, 0);
        if (acc_prev) check(smp_valid_o, "R6 valid after accept", smp_valid_o, 1);
        if (stall_prev) begin
          check(smp_valid_o, "R7 valid dropped under stall", smp_valid_o, 1);
          check(smp_data_o == stall_data, "R7 data changed under stall", smp_data_o, stall_data);
        end
        if (acc_prev) in_grp = 0;
        if (in_grp == 16) begin
          check(!smp_valid_o, "R5 valid after sample 15", smp_valid_o, 0);
          in_grp = 17;
        end
        acc_prev   = grp_valid_i && grp_ready_o;
        stall_prev = smp_valid_o && !smp_ready_i;
        stall_data = smp_data_o;
        if (smp_valid_o && smp_ready_i) begin
          in_grp++;
          if (exp_q.size() == 0) begin
            check(0, "R5 unexpected sample", smp_data_o, 0);
          end else begin
            e = exp_q.pop_front();
            check(smp_data_o[3:0] == e[3:0], "R2 bits 3:0", smp_data_o[3:0], e[3:0]);
            check(smp_data_o[7:4] == e[7:4], "R3 bits 7:4", smp_data_o[7:4], e[7:4]);
            check(smp_data_o[11:8] == e[11:8], "R4 bits 11:8", smp_data_o[11:8], e[11:8]);
            if (!clear_i) begin
              if (m_pv && e != 12'(m_prev + 1)) begin m_err = 1; m_ok = 0; end
              m_prev = e;
              m_pv   = 1;
            end
          end
        end
        if (clear_i) begin m_pv = 0; m_err = 0; m_ok = 1; end
        else if (grp_valid_i && grp_ready_o) m_ok = 1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(!smp_valid_o, "R1 smp_valid_o", smp_valid_o, 0);
    check(grp_ready_o, "R1 grp_ready_o", grp_ready_o, 1);
    check(!seq_err_o, "R1 seq_err_o", seq_err_o, 0);
    check(grp_ok_o, "R1 grp_ok_o", grp_ok_o, 1);

    // clean counting groups with several ready patterns
    rdy_mode = 0; send_group(0, -1, 0);
    rdy_mode = 1; send_group(16, -1, 0);
    rdy_mode = 2; send_group(32, -1, 0);
    drain();

    // wrap 4095 -> 0 inside a group and across groups
    do_clear();
    rdy_mode = 3; send_group(4088, -1, 0); send_group(8, -1, 0);
    drain();

    // single-bit corruption in low nibble lane
    rdy_mode = 0; send_group(24, 6, 2);
    drain();
    // clean continuing group: grp_ok_o returns, seq_err_o stays set
    send_group(40, -1, 0);
    drain();

    // clear then discontinuity at group boundary (R9)
    do_clear();
    rdy_mode = 1; send_group(100, -1, 0);
    send_group(117, -1, 0);
    drain();

    // corruption in upper nibble and single-bit lanes
    do_clear();
    rdy_mode = 2; send_group(500, 12, 6);
    drain();
    do_clear();
    send_group(2000, 3, 11);
    drain();
    do_clear();
    rdy_mode = 0; send_group(1000, 15, 9);
    send_group(1016, -1, 0);
    drain();

    done = 1;
    check(exp_q.size() == 0, "R5 leftover samples", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule